// File: doc/BRIEF.md
# Canonical Signed-Digit Recoder

This block turns an unsigned binary operand into its canonical signed-digit form. In that form each digit is -1, 0 or +1, no two neighbouring digits are both non-zero, and the number of non-zero digits is as small as possible. The block is sequential. A start strobe latches the operand. After that the block produces one digit per clock, beginning at the least significant position, and it writes each digit into a held result vector. A running carry drives the recurrence D_i = B_i + C_i - 2*C_(i+1). The carry C_(i+1) is the carry out of B_(i+1) + B_i + C_i, and the first carry C_0 is zero.

The operand is zero-extended by one position so that the top digit can take up the last carry. A WIDTH-bit operand therefore gives WIDTH+1 digits. Along with the digits, the block reports the weight (the number of non-zero digits) and raises a one-cycle done flag when the last digit is written. Typical users are constant-coefficient multipliers and filter tap generators, which need fewer add/subtract terms when they work from this form.

Top module: `csd_recoder`

## Requirements
- R1: After reset, `digits` is all zero, `weight` is zero and `done` is low.
- R2: Digit i occupies `digits[2i+1:2i]`. The encoding is 2'b00 for 0, 2'b01 for +1 and 2'b11 for -1. The code 2'b10 never appears.
- R3: When `done` is high, the sum of D_i*2^i over all WIDTH+1 digits equals the operand that was accepted. For example, 23 gives +1 at position 5, -1 at position 3 and -1 at position 0.
- R4: When `done` is high, no two adjacent digits are both non-zero. For example, 3 gives +1 at position 2 and -1 at position 0, and 255 (WIDTH=8) gives +1 at position 8 and -1 at position 0.
- R5: When `done` is high, `weight` equals the number of non-zero digits. This is the minimal weight, for example 3 for the operand 23, whose binary weight is 4.
- R6: A start sampled at clock edge k makes `done` high for exactly one cycle, after edge k+WIDTH+1. At all other times `done` stays low.
- R7: A start that arrives while a conversion is running is ignored. Neither the result nor the timing of the running conversion changes.
- R8: A start sampled in the cycle in which `done` is high is accepted and begins a new conversion.
- R9: After `done`, `digits` and `weight` stay unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe. Latches `operand` when the block is idle |
| operand | input | WIDTH | Unsigned binary value to recode |
| digits | output | 2*(WIDTH+1) | Signed-digit vector, two bits per digit |
| weight | output | $clog2(WIDTH+2) | Number of non-zero digits |
| done | output | 1 | One-cycle pulse when the last digit has been written |

## Verification
The done pulse and a new start can fall in the same cycle. The bench provokes this by raising start in the cycle where it has just seen done high, with a fresh random operand. It then judges the new conversion with the reference recoder and counts that its done arrives WIDTH+1 cycles later. A start raised in the middle of a conversion is also provoked, with the complemented operand. That case passes only if the original operand's digits appear, and only at the original time.

// File: rtl/csd_recoder.sv
module csd_recoder #(
  parameter int WIDTH = 8,
  localparam int NDIG = WIDTH + 1,
  localparam int WW = $clog2(WIDTH + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WIDTH-1:0]  operand,
  output logic [2*NDIG-1:0] digits,
  output logic [WW-1:0]     weight,
  output logic              done
);
  localparam int IW = $clog2(NDIG);

  logic [NDIG:0] sh;
  logic          carry;
  logic          busy;
  logic [IW-1:0] idx;

  wire nz    = sh[0] ^ carry;
  wire cnext = (sh[0] & sh[1]) | (sh[0] & carry) | (sh[1] & carry);
  wire [1:0] code = nz ? (sh[1] ? 2'b11 : 2'b01) : 2'b00;
  wire last  = idx == IW'(NDIG - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      carry  <= 1'b0;
      busy   <= 1'b0;
      idx    <= '0;
      digits <= '0;
      weight <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        sh     <= {2'b00, operand};
        carry  <= 1'b0;
        idx    <= '0;
        busy   <= 1'b1;
        digits <= '0;
        weight <= '0;
      end else if (busy) begin
        digits[2*idx +: 2] <= code;
        weight <= weight + WW'(nz);
        sh     <= sh >> 1;
        carry  <= cnext;
        idx    <= idx + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/csd_recoder_chk.sv
module csd_recoder_chk #(
  parameter int WIDTH = 8,
  localparam int NDIG = WIDTH + 1,
  localparam int WW = $clog2(WIDTH + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic [2*NDIG-1:0] digits,
  input logic [WW-1:0]     weight,
  input logic              done
);
  localparam int CW = $clog2(NDIG + 1) + 1;

  logic [CW-1:0]   cnt;
  logic            seen;
  logic            bad;
  logic            adj;
  logic [NDIG-1:0] nzv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (start && !busy) begin
      cnt  <= '0;
      seen <= 1'b1;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    bad = 1'b0;
    adj = 1'b0;
    for (int i = 0; i < NDIG; i++) begin
      nzv[i] = digits[2*i];
      bad = bad | (digits[2*i+1] & ~digits[2*i]);
    end
    for (int i = 0; i < NDIG - 1; i++)
      adj = adj | (digits[2*i] & digits[2*i+2]);
  end

  AST_NO_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n) !bad); // R2
  AST_NON_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n) done |-> !adj); // R4
  AST_WEIGHT_MATCH: assert property (@(posedge clk) disable iff (!rst_n) done |-> ($countones(nzv) == int'(weight))); // R5
  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n) done |-> (seen && cnt == CW'(NDIG))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> ($stable(digits) && $stable(weight))); // R9
endmodule

bind csd_recoder csd_recoder_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_csd_recoder.sv
`timescale 1ns/1ps
module sim_csd_recoder;
  localparam int WIDTH = 8;
  localparam int NDIG = WIDTH + 1;
  localparam int WW = $clog2(WIDTH + 2);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [WIDTH-1:0]  operand = '0;
  logic [2*NDIG-1:0] digits;
  logic [WW-1:0]     weight;
  logic              done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  csd_recoder #(.WIDTH(WIDTH)) u0 (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*NDIG-1:0] ref_csd(input int x);
    logic [2*NDIG-1:0] r;
    int v;
    int d;
    r = '0;
    v = x;
    for (int i = 0; i < NDIG; i++) begin
      if (v % 2 != 0) begin
        d = 2 - (v % 4);
        r[2*i +: 2] = (d > 0) ? 2'b01 : 2'b11;
        v = v - d;
      end
      v = v / 2;
    end
    return r;
  endfunction

  function automatic int value_of(input logic [2*NDIG-1:0] dv);
    int acc;
    acc = 0;
    for (int i = 0; i < NDIG; i++) begin
      if (dv[2*i +: 2] == 2'b01) acc += (1 << i);
      else if (dv[2*i +: 2] == 2'b11) acc -= (1 << i);
    end
    return acc;
  endfunction

  function automatic bit adjacent_nz(input logic [2*NDIG-1:0] dv);
    bit a;
    a = 1'b0;
    for (int i = 0; i < NDIG - 1; i++) a |= dv[2*i] & dv[2*i+2];
    return a;
  endfunction

  function automatic bit has_bad(input logic [2*NDIG-1:0] dv);
    bit b;
    b = 1'b0;
    for (int i = 0; i < NDIG; i++) b |= (dv[2*i +: 2] == 2'b10);
    return b;
  endfunction

  function automatic int nz_count(input logic [2*NDIG-1:0] dv);
    int n;
    n = 0;
    for (int i = 0; i < NDIG; i++) n += int'(dv[2*i]);
    return n;
  endfunction

  task automatic run(input int op, input bit inj, input bit chain);
    logic [2*NDIG-1:0] exp;
    exp = ref_csd(op);
    if (!chain) @(negedge clk);
    start = 1'b1;
    operand = WIDTH'(op);
    @(negedge clk);
    start = 1'b0;
    for (int j = 1; j <= WIDTH; j++) begin
      @(negedge clk);
      chk(done == 1'b0, inj ? "R7 early done" : "R6 early done", int'(done), 0);
      if (inj && j == 3) begin
        start = 1'b1;
        operand = ~WIDTH'(op);
      end
      if (inj && j == 4) start = 1'b0;
    end
    @(negedge clk);
    chk(done == 1'b1, chain ? "R8 done timing" : "R6 done timing", int'(done), 1);
    if (inj) chk(digits == exp, "R7 digits", int'(digits), int'(exp));
    else if (chain) chk(digits == exp, "R8 digits", int'(digits), int'(exp));
    else chk(digits == exp, "R3 digits", int'(digits), int'(exp));
    chk(value_of(digits) == op, "R3 value", value_of(digits), op);
    chk(!adjacent_nz(digits), "R4 adjacency", int'(digits), int'(exp));
    chk(!has_bad(digits), "R2 code", int'(digits), int'(exp));
    chk(int'(weight) == nz_count(exp), "R5 weight", int'(weight), nz_count(exp));
  endtask

  task automatic post_check();
    logic [2*NDIG-1:0] saved;
    logic [WW-1:0] wsaved;
    saved = digits;
    wsaved = weight;
    @(negedge clk);
    chk(done == 1'b0, "R6 single pulse", int'(done), 0);
    chk(digits == saved && weight == wsaved, "R9 hold", int'(digits), int'(saved));
  endtask

  initial begin
    int seed;
    int op;
    bit ch;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(digits == '0, "R1 digits", int'(digits), 0);
    chk(weight == '0, "R1 weight", int'(weight), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);

    run(23, 1'b0, 1'b0);
    chk(digits == 18'b00_00_00_01_00_11_00_00_11, "R3 twenty-three", int'(digits), 18'b00_00_00_01_00_11_00_00_11);
    chk(weight == 3, "R5 twenty-three", int'(weight), 3);
    post_check();
    run(3, 1'b0, 1'b0);
    chk(digits == 18'b00_00_00_00_00_00_01_00_11, "R4 three", int'(digits), 18'b00_00_00_00_00_00_01_00_11);
    post_check();
    run(255, 1'b0, 1'b0);
    chk(digits == 18'b01_00_00_00_00_00_00_00_11, "R4 all ones", int'(digits), 18'b01_00_00_00_00_00_00_00_11);
    post_check();
    run(0, 1'b0, 1'b0);
    chk(digits == '0 && weight == 0, "R3 zero", int'(digits), 0);
    post_check();
    run(170, 1'b1, 1'b0);
    post_check();
    run(91, 1'b0, 1'b0);
    run(200, 1'b0, 1'b1);
    post_check();

    for (int k = 0; k < 60; k++) begin
      op = int'($urandom % 256);
      ch = ($urandom % 3) == 0;
      if (!ch) post_check();
      run(op, (k % 5) == 2, ch);
    end
    post_check();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule